// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a memory-mapped watchdog timer for a system-on-chip. A prescaler divides the system clock into ticks. Each tick decrements a reload counter. When the count runs out, the block raises a one-cycle reset request and starts a new period. Software must keep reloading the counter (a "kick") to stop that request from firing.

Each of the four control words sits behind its own guard register: the kick, the reload value, the run/stop bit and the prescale divider. A guard opens only after software writes a fixed sequence of key words to it. Software can read the guard's progress through that sequence in the low two bits of the guard register. An open guard allows exactly one write to its control word and then closes again. A runaway program therefore cannot stop or retune the watchdog by chance.

The register port is a simple 32-bit bus. It has a byte address, a write strobe, write data and combinational read data. Writes take effect on the rising clock edge that samples them.

Top module: `keyed_wdog`

## Requirements
- R1: Byte address bits [4:2] select a word and bits [1:0] are ignored. The words are: 0 kick guard, 1 kick (reads the live counter), 2 reload guard, 3 reload value, 4 run guard, 5 run bit (bit 0), 6 prescale guard, 7 prescale divider. After reset, every guard reads 0, the counter, the reload value and the divider read 0xFFFF, the run bit reads 0 and `wdogRst` is low.
- R2: Each guard reports its progress in read bits [1:0], with all other bits zero. The kick guard takes the keys 0x5555 then 0xAAAA. The reload guard takes 0x6666 then 0xBBBB. The prescale guard takes 0x5A5A then 0xA5A5. For each of these, progress reads 1 after the first key and 3 after the second.
- R3: The run guard takes three keys: 0x7777, then 0xCCCC, then 0xDDDD. Its progress reads 1, then 2, then 3.
- R4: A guard write that is not the next expected key returns that guard to 0. This covers a wrong value, a key out of order, a value with nonzero upper bits, and any write to a guard that is already open at 3.
- R5: A write to a control word whose guard does not read 3 is ignored. Both the stored value and the guard's progress stay unchanged.
- R6: An accepted control-word write returns its guard to 0, so the next write needs a fresh key sequence.
- R7: An accepted run write stores bit 0. Writing 1 while stopped reloads the counter from the reload value and restarts the prescaler. Writing 0 stops counting, and the counter then holds its value.
- R8: An accepted kick write with bit 0 = 1 reloads the counter from the reload value and restarts the prescaler. With bit 0 = 0 the counter is not affected.
- R9: The reload value and the divider store write bits [15:0]. A stored value of 0 is replaced by 1.
- R10: While running with reload value C and divider P, and C·P > 1, `wdogRst` goes high for exactly one cycle, C·P clock edges after the reloading edge. The counter is reloaded with C on that same edge, and the next period is again C·P edges long.
- R11: While stopped, `wdogRst` stays low and the counter does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W (5) | Byte address of the register word |
| regWe | input | 1 | Write strobe, sampled on the rising edge |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| wdogRst | output | 1 | One-cycle watchdog reset request |

## Verification
Every write changes state on the edge that samples it. Read data is combinational, so a guard's progress or a stored value can be read back at the next falling edge. The bench drives each write across one rising edge and reads at later falling edges.

The reset request is registered and rises just after the C·P-th edge following the reloading edge. The bench counts falling edges from the one right after the kick. It expects to see the pulse at exactly count C·P and expects it gone one falling edge later. The counter is read back after the pulse to confirm it restarted at C.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
  localparam int BUS_W     = 32;
  localparam int KEY_W     = 16;
  localparam int NUM_LOCKS = 4;

  // guard / control word pairs: guard at word 2*idx, control word at 2*idx+1
  localparam int IDX_KICK   = 0;
  localparam int IDX_RELOAD = 1;
  localparam int IDX_RUN    = 2;
  localparam int IDX_SCALE  = 3;

  typedef struct packed {
    logic             kickGo;
    logic             reloadLd;
    logic             runLd;
    logic             scaleLd;
    logic [BUS_W-1:0] wval;
  } strobe_t;

  function automatic int lockSteps(int idx);
    return (idx == IDX_RUN) ? 3 : 2;
  endfunction

  function automatic logic [KEY_W-1:0] lockKey(int idx, int step);
    logic [KEY_W-1:0] k;
    case (idx)
      IDX_KICK:   k = (step == 0) ? 16'h5555 : 16'hAAAA;
      IDX_RELOAD: k = (step == 0) ? 16'h6666 : 16'hBBBB;
      IDX_RUN:    k = (step == 0) ? 16'h7777 : ((step == 1) ? 16'hCCCC : 16'hDDDD);
      default:    k = (step == 0) ? 16'h5A5A : 16'hA5A5;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/keyed_wdog_lock.sv
module keyed_wdog_lock import keyed_wdog_pkg::*; #(
  parameter int STEPS = 2,
  parameter logic [KEY_W-1:0] KEY0 = 16'h0001,
  parameter logic [KEY_W-1:0] KEY1 = 16'h0002,
  parameter logic [KEY_W-1:0] KEY2 = 16'h0003
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lockWr,
  input  logic             dataWr,
  input  logic [BUS_W-1:0] wval,
  output logic             isOpen,
  output logic [1:0]       progress
);
  localparam logic [1:0] LAST = 2'(STEPS);

  logic [1:0]       stageQ;
  logic [KEY_W-1:0] nextKey;
  logic             keyHit;

  always_comb begin
    case (stageQ)
      2'd0:    nextKey = KEY0;
      2'd1:    nextKey = KEY1;
      default: nextKey = KEY2;
    endcase
  end

  assign isOpen   = (stageQ == LAST);
  assign keyHit   = !isOpen && (wval == {{(BUS_W-KEY_W){1'b0}}, nextKey});
  // a finished sequence always reads 3, partial progress reads the step count
  assign progress = isOpen ? 2'd3 : stageQ;

  always_ff @(posedge clk) begin
    if (!rstN)                stageQ <= 2'd0;
    else if (lockWr)          stageQ <= keyHit ? stageQ + 2'd1 : 2'd0;
    else if (dataWr && isOpen) stageQ <= 2'd0;
  end

  assert_badkey_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lockWr && !keyHit) |=> (progress == 2'd0));

  assert_relock_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && isOpen && !lockWr) |=> (progress == 2'd0));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!lockWr && !(dataWr && isOpen)) |=> $stable(progress));

  if (STEPS == 2) begin : g_twoStep
    assert_noTwo_R2: assert property (@(posedge clk) disable iff (!rstN)
      progress != 2'd2);
  end
endmodule

// File: rtl/keyed_wdog_ctrl.sv
module keyed_wdog_ctrl import keyed_wdog_pkg::*; #(
  parameter int ADDR_W = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic                   regWe,
  input  logic [BUS_W-1:0]       regWdata,
  output strobe_t                strobes,
  output logic [NUM_LOCKS*2-1:0] progressAll
);
  logic [2:0]           wordIdx;
  logic [NUM_LOCKS-1:0] lockWrV, dataWrV, openV, acceptV;
  logic                 unusedAddr;

  assign wordIdx    = regAddr[2 +: 3];
  assign unusedAddr = ^regAddr[1:0];

  for (genvar gi = 0; gi < NUM_LOCKS; gi++) begin : g_lock
    localparam int STEPS_G = lockSteps(gi);
    localparam logic [KEY_W-1:0] K0 = lockKey(gi, 0);
    localparam logic [KEY_W-1:0] K1 = lockKey(gi, 1);
    localparam logic [KEY_W-1:0] K2 = lockKey(gi, 2);

    assign lockWrV[gi] = regWe && (wordIdx == 3'(2 * gi));
    assign dataWrV[gi] = regWe && (wordIdx == 3'(2 * gi + 1));
    assign acceptV[gi] = dataWrV[gi] && openV[gi];

    keyed_wdog_lock #(.STEPS(STEPS_G), .KEY0(K0), .KEY1(K1), .KEY2(K2)) u_lock (
      .clk      (clk),
      .rstN     (rstN),
      .lockWr   (lockWrV[gi]),
      .dataWr   (dataWrV[gi]),
      .wval     (regWdata),
      .isOpen   (openV[gi]),
      .progress (progressAll[2*gi +: 2])
    );
  end

  always_comb begin
    strobes.kickGo   = acceptV[IDX_KICK] && regWdata[0];
    strobes.reloadLd = acceptV[IDX_RELOAD];
    strobes.runLd    = acceptV[IDX_RUN];
    strobes.scaleLd  = acceptV[IDX_SCALE];
    strobes.wval     = regWdata;
  end

  assert_oneStrobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.kickGo, strobes.reloadLd, strobes.runLd, strobes.scaleLd}));
endmodule

// File: rtl/keyed_wdog_dp.sv
module keyed_wdog_dp import keyed_wdog_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  output logic [CNT_W-1:0] countOut,
  output logic [CNT_W-1:0] reloadOut,
  output logic [CNT_W-1:0] scaleOut,
  output logic             runOut,
  output logic             wdogRst
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] reloadQ, scaleQ, countQ, preQ, loadVal;
  logic             runQ, pulseQ, tick, startRun, restart;
  logic             unusedHigh;

  function automatic logic [CNT_W-1:0] clampLoad(logic [CNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  assign loadVal    = clampLoad(strobes.wval[CNT_W-1:0]);
  assign unusedHigh = ^strobes.wval[BUS_W-1:CNT_W];
  assign tick       = runQ && (preQ >= scaleQ - ONE);
  assign startRun   = strobes.runLd && strobes.wval[0] && !runQ;
  assign restart    = strobes.kickGo || startRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ <= '1;
      scaleQ  <= '1;
      runQ    <= 1'b0;
    end else begin
      if (strobes.reloadLd) reloadQ <= loadVal;
      if (strobes.scaleLd)  scaleQ  <= loadVal;
      if (strobes.runLd)    runQ    <= strobes.wval[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '1;
      preQ   <= '0;
      pulseQ <= 1'b0;
    end else if (restart) begin
      countQ <= reloadQ;
      preQ   <= '0;
      pulseQ <= 1'b0;
    end else if (!runQ) begin
      preQ   <= '0;
      pulseQ <= 1'b0;
    end else if (tick) begin
      preQ <= '0;
      if (countQ == ONE) begin
        countQ <= reloadQ;
        pulseQ <= 1'b1;
      end else begin
        countQ <= countQ - ONE;
        pulseQ <= 1'b0;
      end
    end else begin
      preQ   <= preQ + ONE;
      pulseQ <= 1'b0;
    end
  end

  assign countOut  = countQ;
  assign reloadOut = reloadQ;
  assign scaleOut  = scaleQ;
  assign runOut    = runQ;
  assign wdogRst   = pulseQ;

  assert_pulseRunning_R11: assert property (@(posedge clk) disable iff (!rstN)
    wdogRst |-> $past(runQ));

  assert_stoppedHold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ && !restart) |=> $stable(countQ));

  assert_kickReload_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.kickGo |=> (countQ == $past(reloadQ)));

  assert_clampZero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.reloadLd && strobes.wval[CNT_W-1:0] == '0) |=> (reloadQ == ONE));

  assert_stepDown_R10: assert property (@(posedge clk) disable iff (!rstN)
    (tick && countQ != ONE && !restart) |=> (countQ == $past(countQ) - ONE));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog import keyed_wdog_pkg::*; #(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [BUS_W-1:0]  regWdata,
  output logic [BUS_W-1:0]  regRdata,
  output logic              wdogRst
);
  localparam int PAD_W = BUS_W - CNT_W;

  strobe_t                strobes;
  logic [NUM_LOCKS*2-1:0] progressAll;
  logic [CNT_W-1:0]       countOut, reloadOut, scaleOut;
  logic                   runOut;

  keyed_wdog_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regAddr     (regAddr),
    .regWe       (regWe),
    .regWdata    (regWdata),
    .strobes     (strobes),
    .progressAll (progressAll)
  );

  keyed_wdog_dp #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .countOut  (countOut),
    .reloadOut (reloadOut),
    .scaleOut  (scaleOut),
    .runOut    (runOut),
    .wdogRst   (wdogRst)
  );

  always_comb begin
    case (regAddr[2 +: 3])
      3'd0:    regRdata = {30'b0, progressAll[2*IDX_KICK +: 2]};
      3'd1:    regRdata = {{PAD_W{1'b0}}, countOut};
      3'd2:    regRdata = {30'b0, progressAll[2*IDX_RELOAD +: 2]};
      3'd3:    regRdata = {{PAD_W{1'b0}}, reloadOut};
      3'd4:    regRdata = {30'b0, progressAll[2*IDX_RUN +: 2]};
      3'd5:    regRdata = {31'b0, runOut};
      3'd6:    regRdata = {30'b0, progressAll[2*IDX_SCALE +: 2]};
      default: regRdata = {{PAD_W{1'b0}}, scaleOut};
    endcase
  end
endmodule

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb;
  localparam int CLK_PERIOD = 10;

  localparam logic [4:0] A_KLOCK = 5'h00, A_KICK  = 5'h04;
  localparam logic [4:0] A_CLOCK = 5'h08, A_CHG   = 5'h0C;
  localparam logic [4:0] A_RLOCK = 5'h10, A_RUN   = 5'h14;
  localparam logic [4:0] A_PLOCK = 5'h18, A_SCALE = 5'h1C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        wdogRst;

  int total = 0;
  int bad = 0;

  keyed_wdog u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .wdogRst(wdogRst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWe = 1'b1; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic openTwo(input logic [4:0] a, input logic [31:0] k0, input logic [31:0] k1);
    wr(a, k0); wr(a, k1);
  endtask

  task automatic openRun();
    wr(A_RLOCK, 32'h7777); wr(A_RLOCK, 32'hCCCC); wr(A_RLOCK, 32'hDDDD);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_KLOCK, v); chk("R1 kick guard reset", v, 0);
    rd(A_CLOCK, v); chk("R1 reload guard reset", v, 0);
    rd(A_RLOCK, v); chk("R1 run guard reset", v, 0);
    rd(A_PLOCK, v); chk("R1 prescale guard reset", v, 0);
    rd(A_KICK, v);  chk("R1 counter reset", v, 32'hFFFF);
    rd(A_CHG, v);   chk("R1 reload reset", v, 32'hFFFF);
    rd(A_RUN, v);   chk("R1 run reset", v, 0);
    rd(A_SCALE, v); chk("R1 divider reset", v, 32'hFFFF);
    rd(5'h1F, v);   chk("R1 low address bits ignored", v, 32'hFFFF);
    chk("R1 wdogRst reset", {31'b0, wdogRst}, 0);
  endtask

  task automatic t_sequences();
    logic [31:0] v;
    wr(A_KLOCK, 32'h5555); rd(A_KLOCK, v); chk("R2 kick step1", v, 1);
    wr(A_KLOCK, 32'hAAAA); rd(A_KLOCK, v); chk("R2 kick step2", v, 3);
    wr(A_KLOCK, 32'h0);    rd(A_KLOCK, v); chk("R4 open kick guard rewrite", v, 0);
    wr(A_CLOCK, 32'h6666); rd(A_CLOCK, v); chk("R2 reload step1", v, 1);
    wr(A_CLOCK, 32'hBBBB); rd(A_CLOCK, v); chk("R2 reload step2", v, 3);
    wr(A_CLOCK, 32'h6666); rd(A_CLOCK, v); chk("R4 open reload guard key0", v, 0);
    wr(A_PLOCK, 32'h5A5A); rd(A_PLOCK, v); chk("R2 prescale step1", v, 1);
    wr(A_PLOCK, 32'hA5A5); rd(A_PLOCK, v); chk("R2 prescale step2", v, 3);
    wr(A_PLOCK, 32'h1);    rd(A_PLOCK, v); chk("R4 open prescale guard rewrite", v, 0);
    wr(A_RLOCK, 32'h7777); rd(A_RLOCK, v); chk("R3 run step1", v, 1);
    wr(A_RLOCK, 32'hCCCC); rd(A_RLOCK, v); chk("R3 run step2", v, 2);
    wr(A_RLOCK, 32'hDDDD); rd(A_RLOCK, v); chk("R3 run step3", v, 3);
    wr(A_RLOCK, 32'h0);    rd(A_RLOCK, v); chk("R4 open run guard rewrite", v, 0);
  endtask

  task automatic t_badKeys();
    logic [31:0] v;
    wr(A_KLOCK, 32'hAAAA); rd(A_KLOCK, v); chk("R4 second key first", v, 0);
    wr(A_KLOCK, 32'h5555); wr(A_KLOCK, 32'h1234);
    rd(A_KLOCK, v); chk("R4 wrong second key", v, 0);
    wr(A_RLOCK, 32'h7777); wr(A_RLOCK, 32'hDDDD);
    rd(A_RLOCK, v); chk("R4 run key skipped", v, 0);
    wr(A_KLOCK, 32'h0001_5555); rd(A_KLOCK, v); chk("R4 upper bits set", v, 0);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    wr(A_CHG, 32'h10); rd(A_CHG, v); chk("R5 locked write ignored", v, 32'hFFFF);
    rd(A_CLOCK, v); chk("R5 guard untouched by locked write", v, 0);
    wr(A_CLOCK, 32'h6666);
    wr(A_CHG, 32'h10); rd(A_CHG, v); chk("R5 partial unlock write ignored", v, 32'hFFFF);
    rd(A_CLOCK, v); chk("R5 partial progress kept", v, 1);
    wr(A_CLOCK, 32'h0);
    wr(A_RUN, 32'h1); rd(A_RUN, v); chk("R5 locked run write ignored", v, 0);
  endtask

  task automatic t_accept();
    logic [31:0] v;
    openTwo(A_CLOCK, 32'h6666, 32'hBBBB);
    wr(A_CHG, 32'h0001_2345); rd(A_CHG, v); chk("R9 reload low 16 bits", v, 32'h2345);
    rd(A_CLOCK, v); chk("R6 reload guard relocked", v, 0);
    wr(A_CHG, 32'h7); rd(A_CHG, v); chk("R6 second write needs unlock", v, 32'h2345);
    openTwo(A_CLOCK, 32'h6666, 32'hBBBB);
    wr(A_CHG, 32'h0); rd(A_CHG, v); chk("R9 reload zero clamps", v, 1);
    openTwo(A_PLOCK, 32'h5A5A, 32'hA5A5);
    wr(A_SCALE, 32'h0); rd(A_SCALE, v); chk("R9 divider zero clamps", v, 1);
    rd(A_PLOCK, v); chk("R6 prescale guard relocked", v, 0);
  endtask

  task automatic t_kick();
    logic [31:0] v;
    openTwo(A_CLOCK, 32'h6666, 32'hBBBB); wr(A_CHG, 32'h9);
    openTwo(A_KLOCK, 32'h5555, 32'hAAAA); wr(A_KICK, 32'h0);
    rd(A_KICK, v); chk("R8 kick with bit0=0 no reload", v, 32'hFFFF);
    rd(A_KLOCK, v); chk("R6 kick guard relocked", v, 0);
    wr(A_KICK, 32'h1); rd(A_KICK, v); chk("R5 locked kick ignored", v, 32'hFFFF);
    openTwo(A_KLOCK, 32'h5555, 32'hAAAA); wr(A_KICK, 32'h1);
    rd(A_KICK, v); chk("R8 kick reloads counter", v, 9);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    int n;
    openTwo(A_PLOCK, 32'h5A5A, 32'hA5A5); wr(A_SCALE, 32'h3);
    openTwo(A_CLOCK, 32'h6666, 32'hBBBB); wr(A_CHG, 32'h4);
    openRun(); wr(A_RUN, 32'h1);
    rd(A_RUN, v); chk("R7 run bit set", v, 1);
    openTwo(A_KLOCK, 32'h5555, 32'hAAAA); wr(A_KICK, 32'h1);
    n = 0;
    while (!wdogRst && n < 1000) begin @(negedge clk); n++; end
    chk("R10 first period edges", n, 12);
    @(negedge clk);
    chk("R10 pulse one cycle", {31'b0, wdogRst}, 0);
    #1 regAddr = A_KICK; #1 v = regRdata;
    chk("R10 counter reloaded", v, 4);
    n = 1;
    while (!wdogRst && n < 1000) begin @(negedge clk); n++; end
    chk("R10 second period edges", n, 12);
  endtask

  task automatic t_stop();
    logic [31:0] v1, v2;
    int seen;
    openRun(); wr(A_RUN, 32'h0);
    rd(A_RUN, v1); chk("R7 run bit cleared", v1, 0);
    rd(A_KICK, v1);
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (wdogRst) seen++; end
    chk("R11 no pulse while stopped", seen, 0);
    rd(A_KICK, v2); chk("R11 counter holds while stopped", v2, v1);
    openRun(); wr(A_RUN, 32'h1);
    rd(A_KICK, v2); chk("R7 start reloads counter", v2, 4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_sequences();
    t_badKeys();
    t_ignored();
    t_accept();
    t_kick();
    t_timeout();
    t_stop();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule